// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

The mapper sits between an 8-bit CPU with a 16-bit address bus and a cartridge holding a large ROM and a banked battery-backed RAM. Reads in the lower half of the address space go to the ROM. The lowest 16 KiB always shows ROM bank 0. The next 16 KiB shows a selectable bank. An 8 KiB window higher up reaches one bank of external RAM.

The ROM is never written. CPU writes into the ROM half are decoded as control commands, and four 8 KiB sub-windows pick the command. The first enables or disables RAM access. The second loads the ROM bank number. The third picks a RAM bank, or one of a group of clock registers whose codes sit apart from the RAM bank codes. The fourth takes clock-latch commands.

Clock-register accesses are a stub: reads return zero and writes are dropped. A valid latch sequence produces a one-cycle pulse for a later clock block. Bad selector or latch codes produce a one-cycle error pulse. Address translation and read-data steering are combinational. Register updates take effect on the clock edge that samples the write strobe.

Top module: `cart_mapper`

## Requirements
- R1: A read with address 0x0000–0x3FFF asserts `rom_cs_o` and drives `rom_addr_o` equal to the address (bank 0). `cpu_rdata_o` returns `rom_rdata_i`.
- R2: A read with address 0x4000–0x7FFF drives `rom_addr_o` = bank × 0x4000 + (address − 0x4000), where bank is the stored ROM bank. `cpu_rdata_o` returns `rom_rdata_i`.
- R3: A write to 0x2000–0x3FFF stores the low 7 bits of the data as the ROM bank. A stored value of 0 becomes 1.
- R4: After reset the ROM bank is 1, the RAM bank is 0, RAM access is disabled, and `latch_pulse_o` and `cfg_err_o` are low.
- R5: A write to 0x0000–0x1FFF with data 0x0A enables RAM access and data 0x00 disables it. Any other data leaves the enable unchanged and raises no error.
- R6: A write to 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank, and data 0x08–0x0C selects the clock-register stub. Any other data leaves the selection unchanged and pulses `cfg_err_o` high for the one cycle after the write edge.
- R7: When RAM access is enabled and a RAM bank is selected, a read or write of 0xA000–0xBFFF asserts `ram_cs_o` and drives `ram_addr_o` = bank × 0x2000 + (address − 0xA000). A write also asserts `ram_we_o` with `ram_wdata_o` equal to the CPU data, and a read returns `ram_rdata_i`.
- R8: When the clock stub is selected and RAM access is enabled, a read of 0xA000–0xBFFF returns 0x00. `ram_cs_o` and `ram_we_o` stay low.
- R9: When RAM access is disabled, a read of 0xA000–0xBFFF returns 0xFF. `ram_cs_o` and `ram_we_o` stay low.
- R10: In 0x6000–0x7FFF, a write of 0x01 that directly follows a write of 0x00 there pulses `latch_pulse_o` high for the one cycle after the edge. A 0x01 not preceded by 0x00 gives no pulse. Any data other than 0x00 or 0x01 pulses `cfg_err_o` and clears the pending 0x00.
- R11: `rom_cs_o` is asserted only for reads. A write anywhere in 0x0000–0x7FFF never asserts it.
- R12: A read of 0x8000–0x9FFF or 0xC000–0xFFFF returns 0xFF with `rom_cs_o` and `ram_cs_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | Read strobe, one cycle |
| cpu_wr_i | input | 1 | Write strobe, one cycle |
| cpu_rdata_o | output | 8 | Read data to the CPU |
| rom_addr_o | output | 21 | Physical ROM address |
| rom_cs_o | output | 1 | ROM chip select |
| rom_rdata_i | input | 8 | ROM data |
| ram_addr_o | output | 15 | Physical RAM address |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM data |
| latch_pulse_o | output | 1 | One-cycle clock-latch request |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected selector or latch code |

## Verification
Read data, addresses and chip selects come out in the same cycle as the strobe. The bench samples them two nanoseconds after the falling edge on which it raised the strobe, before the capturing rising edge. A register write takes effect on the rising edge that samples the strobe, so its effect is checked with the next access. `latch_pulse_o` and `cfg_err_o` are registered: the bench samples them two nanoseconds after that same edge, and checks again one cycle later that they have dropped.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

  typedef enum logic [1:0] {
    RG_ROM0 = 2'd0,
    RG_ROMX = 2'd1,
    RG_RAM  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  // control sub-window inside the ROM half, by address bits 14:13
  typedef enum logic [1:0] {
    CW_ENABLE  = 2'd0,
    CW_ROMBANK = 2'd1,
    CW_RAMSEL  = 2'd2,
    CW_LATCH   = 2'd3
  } ctrl_win_e;

  localparam logic [7:0] EN_ON       = 8'h0A;
  localparam logic [7:0] EN_OFF      = 8'h00;
  localparam logic [7:0] CLK_CODE_LO = 8'h08;
  localparam logic [7:0] CLK_CODE_HI = 8'h0C;
  localparam logic [7:0] LATCH_ARM   = 8'h00;
  localparam logic [7:0] LATCH_FIRE  = 8'h01;
  localparam logic [7:0] OPEN_BUS    = 8'hFF;
  localparam logic [7:0] STUB_DATA   = 8'h00;

  function automatic region_e decode_region(input logic [15:0] a);
    if (!a[15])               return a[14] ? RG_ROMX : RG_ROM0;
    else if (a[14:13] == 2'b01) return RG_RAM;
    else                      return RG_NONE;
  endfunction

  function automatic ctrl_win_e decode_ctrl(input logic [15:0] a);
    return ctrl_win_e'(a[14:13]);
  endfunction

endpackage

// File: rtl/cart_reg_file.sv
module cart_reg_file
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  ctrl_win_e             win_i,
  input  logic [7:0]            data_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  ram_on_o,
  output logic                  clk_sel_o,
  output logic                  sel_err_o
);

  localparam logic [ROM_BANK_W-1:0] ROM_BANK_RST = ROM_BANK_W'(1);

  logic                  sel_ram_ok, sel_clk_ok;
  logic [ROM_BANK_W-1:0] rom_bank_nxt;

  assign sel_ram_ok = (data_i >> RAM_BANK_W) == 8'h00;
  assign sel_clk_ok = (data_i >= CLK_CODE_LO) && (data_i <= CLK_CODE_HI);

  // bank 0 is never mapped into the switchable window
  always_comb begin
    rom_bank_nxt = data_i[ROM_BANK_W-1:0];
    if (rom_bank_nxt == '0) rom_bank_nxt = ROM_BANK_RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= ROM_BANK_RST;
      ram_bank_o <= '0;
      ram_on_o   <= 1'b0;
      clk_sel_o  <= 1'b0;
      sel_err_o  <= 1'b0;
    end else begin
      sel_err_o <= 1'b0;
      if (wr_en_i) begin
        unique case (win_i)
          CW_ENABLE: begin
            if (data_i == EN_ON)       ram_on_o <= 1'b1;
            else if (data_i == EN_OFF) ram_on_o <= 1'b0;
          end
          CW_ROMBANK: rom_bank_o <= rom_bank_nxt;
          CW_RAMSEL: begin
            if (sel_ram_ok) begin
              ram_bank_o <= data_i[RAM_BANK_W-1:0];
              clk_sel_o  <= 1'b0;
            end else if (sel_clk_ok) begin
              clk_sel_o  <= 1'b1;
            end else begin
              sel_err_o  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cart_latch_ctl.sv
module cart_latch_ctl
  import cart_mapper_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] data_i,
  output logic       latch_pulse_o,
  output logic       cmd_err_o
);

  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q       <= 1'b0;
      latch_pulse_o <= 1'b0;
      cmd_err_o     <= 1'b0;
    end else begin
      latch_pulse_o <= 1'b0;
      cmd_err_o     <= 1'b0;
      if (wr_en_i) begin
        if (data_i == LATCH_ARM) begin
          armed_q <= 1'b1;
        end else if (data_i == LATCH_FIRE) begin
          armed_q       <= 1'b0;
          latch_pulse_o <= armed_q;
        end else begin
          armed_q   <= 1'b0;
          cmd_err_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cart_addr_xlat.sv
module cart_addr_xlat
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = 14 + ROM_BANK_W,
  localparam int RAM_AW    = 13 + RAM_BANK_W
) (
  input  logic [15:0]           addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [7:0]            wdata_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [RAM_BANK_W-1:0] ram_bank_i,
  input  logic                  ram_on_i,
  input  logic                  clk_sel_i,
  input  logic [7:0]            rom_rdata_i,
  input  logic [7:0]            ram_rdata_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic                  rom_cs_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_cs_o,
  output logic                  ram_we_o,
  output logic [7:0]            ram_wdata_o,
  output logic [7:0]            rdata_o
);

  region_e rgn;
  logic    ram_path_ok, ram_hit;

  assign rgn         = decode_region(addr_i);
  assign ram_path_ok = ram_on_i && !clk_sel_i;
  assign ram_hit     = (rgn == RG_RAM) && ram_path_ok;

  always_comb begin
    if (rgn == RG_ROM0) rom_addr_o = {{ROM_BANK_W{1'b0}}, addr_i[13:0]};
    else                rom_addr_o = {rom_bank_i, addr_i[13:0]};
  end

  assign rom_cs_o    = rd_i && !wr_i && ((rgn == RG_ROM0) || (rgn == RG_ROMX));
  assign ram_addr_o  = {ram_bank_i, addr_i[12:0]};
  assign ram_cs_o    = (rd_i || wr_i) && ram_hit;
  assign ram_we_o    = wr_i && ram_hit;
  assign ram_wdata_o = wdata_i;

  always_comb begin
    unique case (rgn)
      RG_ROM0, RG_ROMX: rdata_o = rom_rdata_i;
      RG_RAM: begin
        if (!ram_on_i)     rdata_o = OPEN_BUS;
        else if (clk_sel_i) rdata_o = STUB_DATA;
        else               rdata_o = ram_rdata_i;
      end
      default: rdata_o = OPEN_BUS;
    endcase
  end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = 14 + ROM_BANK_W,
  localparam int RAM_AW    = 13 + RAM_BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  output logic [7:0]        cpu_rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_cs_o,
  input  logic [7:0]        rom_rdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              latch_pulse_o,
  output logic              cfg_err_o
);

  ctrl_win_e             win;
  logic                  ctrl_wr, latch_wr;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_on, clk_sel, sel_err, latch_err;

  assign win      = decode_ctrl(cpu_addr_i);
  assign ctrl_wr  = cpu_wr_i && !cpu_addr_i[15];
  assign latch_wr = ctrl_wr && (win == CW_LATCH);

  cart_reg_file #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ctrl_wr),
    .win_i     (win),
    .data_i    (cpu_wdata_i),
    .rom_bank_o(rom_bank),
    .ram_bank_o(ram_bank),
    .ram_on_o  (ram_on),
    .clk_sel_o (clk_sel),
    .sel_err_o (sel_err)
  );

  cart_latch_ctl i_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (latch_wr),
    .data_i       (cpu_wdata_i),
    .latch_pulse_o(latch_pulse_o),
    .cmd_err_o    (latch_err)
  );

  cart_addr_xlat #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
  ) i_xlat (
    .addr_i     (cpu_addr_i),
    .rd_i       (cpu_rd_i),
    .wr_i       (cpu_wr_i),
    .wdata_i    (cpu_wdata_i),
    .rom_bank_i (rom_bank),
    .ram_bank_i (ram_bank),
    .ram_on_i   (ram_on),
    .clk_sel_i  (clk_sel),
    .rom_rdata_i(rom_rdata_i),
    .ram_rdata_i(ram_rdata_i),
    .rom_addr_o (rom_addr_o),
    .rom_cs_o   (rom_cs_o),
    .ram_addr_o (ram_addr_o),
    .ram_cs_o   (ram_cs_o),
    .ram_we_o   (ram_we_o),
    .ram_wdata_o(ram_wdata_o),
    .rdata_o    (cpu_rdata_o)
  );

  assign cfg_err_o = sel_err || latch_err;

endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int ROM_BANK_W = 7,
  localparam int ROM_AW    = 14 + ROM_BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic [7:0]        cpu_wdata_i,
  input logic              cpu_rd_i,
  input logic              cpu_wr_i,
  input logic [7:0]        cpu_rdata_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              rom_cs_o,
  input logic              ram_cs_o,
  input logic              ram_we_o,
  input logic              latch_pulse_o,
  input logic              cfg_err_o
);

  a_r11_rom_cs_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> (cpu_rd_i && !cpu_wr_i && !cpu_addr_i[15]));

  a_r1_bank0_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_wr_i && cpu_addr_i[15:14] == 2'b00)
      |-> (rom_cs_o && rom_addr_o == ROM_AW'(cpu_addr_i[13:0])));

  a_r7_ram_we_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (cpu_wr_i && ram_cs_o && cpu_addr_i[15:13] == 3'b101));

  a_r12_unmapped_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && cpu_addr_i[15] && cpu_addr_i[14:13] != 2'b01)
      |-> (!rom_cs_o && !ram_cs_o && cpu_rdata_o == 8'hFF));

  a_r10_latch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_pulse_o |=> !latch_pulse_o);

  a_r10_latch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_pulse_o) |-> $past(cpu_wr_i && cpu_addr_i[15:13] == 3'b011
                                   && cpu_wdata_i == 8'h01));

  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(cpu_wr_i && cpu_addr_i[15:14] == 2'b01));

endmodule

bind cart_mapper cart_mapper_chk #(.ROM_BANK_W(ROM_BANK_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_wdata_i  (cpu_wdata_i),
  .cpu_rd_i     (cpu_rd_i),
  .cpu_wr_i     (cpu_wr_i),
  .cpu_rdata_o  (cpu_rdata_o),
  .rom_addr_o   (rom_addr_o),
  .rom_cs_o     (rom_cs_o),
  .ram_cs_o     (ram_cs_o),
  .ram_we_o     (ram_we_o),
  .latch_pulse_o(latch_pulse_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/test_cart_mapper.sv
`timescale 1ns/1ps
module test_cart_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_rdata;
  logic [14:0] ram_addr;
  logic        ram_cs, ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        latch_pulse, cfg_err;

  int n_chk = 0, n_bad = 0;

  // snapshots
  logic [7:0]  s_rdata, s_wdata;
  logic [20:0] s_rom_addr;
  logic [14:0] s_ram_addr;
  logic        s_rom_cs, s_ram_cs, s_ram_we, s_latch, s_err, s_latch2, s_err2;

  always #5 clk = ~clk;

  // memory models: data is a function of the physical address
  assign rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};
  assign ram_rdata = ram_addr[7:0] ^ {ram_addr[14:13], 6'h15};

  function automatic logic [7:0] rom_val(logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]};
  endfunction
  function automatic logic [7:0] ram_val(logic [14:0] a);
    return a[7:0] ^ {a[14:13], 6'h15};
  endfunction

  cart_mapper i_cart_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_rdata_o(rdata),
    .rom_addr_o(rom_addr), .rom_cs_o(rom_cs), .rom_rdata_i(rom_rdata),
    .ram_addr_o(ram_addr), .ram_cs_o(ram_cs), .ram_we_o(ram_we),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .latch_pulse_o(latch_pulse), .cfg_err_o(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_rd(logic [15:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2;
    s_rdata = rdata; s_rom_addr = rom_addr; s_rom_cs = rom_cs;
    s_ram_addr = ram_addr; s_ram_cs = ram_cs;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #2;
    s_rom_cs = rom_cs; s_ram_cs = ram_cs; s_ram_we = ram_we;
    s_ram_addr = ram_addr; s_wdata = ram_wdata;
    @(posedge clk);
    #2;
    wr = 1'b0;
    s_latch = latch_pulse; s_err = cfg_err;
    @(posedge clk);
    #2;
    s_latch2 = latch_pulse; s_err2 = cfg_err;
    chk("R11 rom_cs on write", {31'b0, s_rom_cs}, 0);
  endtask

  task automatic t_reset;
    chk("R4 latch after reset", {31'b0, latch_pulse}, 0);
    chk("R4 err after reset", {31'b0, cfg_err}, 0);
    cpu_rd(16'h4000);
    chk("R4 rom bank 1", {11'b0, s_rom_addr}, 32'h4000);
    cpu_rd(16'hA010);
    chk("R4 ram disabled", {24'b0, s_rdata}, 32'hFF);
    chk("R4 ram cs off", {31'b0, s_ram_cs}, 0);
  endtask

  task automatic t_rom0;
    cpu_rd(16'h1234);
    chk("R1 addr", {11'b0, s_rom_addr}, 32'h1234);
    chk("R1 cs", {31'b0, s_rom_cs}, 1);
    chk("R1 data", {24'b0, s_rdata}, {24'b0, rom_val(21'h1234)});
    cpu_rd(16'h3FFF);
    chk("R1 top addr", {11'b0, s_rom_addr}, 32'h3FFF);
  endtask

  task automatic t_romx;
    cpu_wr(16'h2100, 8'h85);
    cpu_rd(16'h4ABC);
    chk("R3 low 7 bits", {11'b0, s_rom_addr}, 5 * 32'h4000 + 32'h0ABC);
    chk("R2 data", {24'b0, s_rdata}, {24'b0, rom_val(21'(5 * 32'h4000 + 32'h0ABC))});
    cpu_wr(16'h3FFF, 8'h7F);
    cpu_rd(16'h7FFF);
    chk("R2 max bank", {11'b0, s_rom_addr}, 32'h1FFFFF);
    chk("R2 cs", {31'b0, s_rom_cs}, 1);
    cpu_wr(16'h2000, 8'h00);
    cpu_rd(16'h4001);
    chk("R3 zero maps to 1", {11'b0, s_rom_addr}, 32'h4001);
    cpu_wr(16'h2000, 8'h80);
    cpu_rd(16'h4002);
    chk("R3 0x80 maps to 1", {11'b0, s_rom_addr}, 32'h4002);
  endtask

  task automatic t_enable;
    cpu_wr(16'h0000, 8'h0A);
    cpu_rd(16'hA123);
    chk("R5 enable", {24'b0, s_rdata}, {24'b0, ram_val(15'h0123)});
    cpu_wr(16'h1FFF, 8'h55);
    chk("R5 no err", {31'b0, s_err}, 0);
    cpu_rd(16'hA123);
    chk("R5 other value keeps", {24'b0, s_rdata}, {24'b0, ram_val(15'h0123)});
    cpu_wr(16'h0800, 8'h00);
    cpu_rd(16'hA123);
    chk("R9 disabled read", {24'b0, s_rdata}, 32'hFF);
    chk("R9 disabled cs", {31'b0, s_ram_cs}, 0);
    cpu_wr(16'hA123, 8'h77);
    chk("R9 disabled we", {31'b0, s_ram_we}, 0);
  endtask

  task automatic t_ram;
    cpu_wr(16'h0000, 8'h0A);
    cpu_wr(16'h4000, 8'h02);
    chk("R6 valid no err", {31'b0, s_err}, 0);
    cpu_wr(16'hA123, 8'h3C);
    chk("R7 we", {31'b0, s_ram_we}, 1);
    chk("R7 cs", {31'b0, s_ram_cs}, 1);
    chk("R7 addr", {17'b0, s_ram_addr}, 32'h4123);
    chk("R7 wdata", {24'b0, s_wdata}, 32'h3C);
    cpu_wr(16'h5FFF, 8'h03);
    cpu_rd(16'hBFFF);
    chk("R7 read addr", {17'b0, s_ram_addr}, 32'h7FFF);
    chk("R7 read data", {24'b0, s_rdata}, {24'b0, ram_val(15'h7FFF)});
  endtask

  task automatic t_clk_sel;
    cpu_wr(16'h4000, 8'h08);
    cpu_rd(16'hA000);
    chk("R8 stub read", {24'b0, s_rdata}, 0);
    chk("R8 stub cs", {31'b0, s_ram_cs}, 0);
    cpu_wr(16'hA000, 8'h99);
    chk("R8 stub we", {31'b0, s_ram_we}, 0);
    cpu_wr(16'h4000, 8'h0C);
    chk("R6 0x0C no err", {31'b0, s_err}, 0);
    cpu_wr(16'h4000, 8'h05);
    chk("R6 bad code err", {31'b0, s_err}, 1);
    chk("R6 err one cycle", {31'b0, s_err2}, 0);
    cpu_rd(16'hA000);
    chk("R6 bad code keeps clock", {24'b0, s_rdata}, 0);
    cpu_wr(16'h4000, 8'h01);
    cpu_wr(16'h4000, 8'h0D);
    chk("R6 0x0D err", {31'b0, s_err}, 1);
    cpu_rd(16'hA456);
    chk("R6 bank kept", {17'b0, s_ram_addr}, 32'h2456);
    chk("R7 bank1 data", {24'b0, s_rdata}, {24'b0, ram_val(15'h2456)});
  endtask

  task automatic t_latch;
    cpu_wr(16'h6000, 8'h00);
    chk("R10 arm no pulse", {31'b0, s_latch}, 0);
    cpu_wr(16'h7FFF, 8'h01);
    chk("R10 pulse", {31'b0, s_latch}, 1);
    chk("R10 single", {31'b0, s_latch2}, 0);
    cpu_wr(16'h6000, 8'h01);
    chk("R10 no rearm", {31'b0, s_latch}, 0);
    cpu_wr(16'h6000, 8'h00);
    cpu_wr(16'h6000, 8'h02);
    chk("R10 bad value err", {31'b0, s_err}, 1);
    chk("R10 err one cycle", {31'b0, s_err2}, 0);
    cpu_wr(16'h6000, 8'h01);
    chk("R10 bad clears arm", {31'b0, s_latch}, 0);
  endtask

  task automatic t_unmapped;
    cpu_rd(16'h8000);
    chk("R12 8000 data", {24'b0, s_rdata}, 32'hFF);
    chk("R12 8000 rom cs", {31'b0, s_rom_cs}, 0);
    cpu_rd(16'hC000);
    chk("R12 C000 data", {24'b0, s_rdata}, 32'hFF);
    chk("R12 C000 ram cs", {31'b0, s_ram_cs}, 0);
    cpu_rd(16'hFFFF);
    chk("R12 FFFF data", {24'b0, s_rdata}, 32'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    t_reset();
    t_rom0();
    t_romx();
    t_enable();
    t_ram();
    t_clk_sel();
    t_latch();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule